// File: doc/BRIEF.md
# IDE Port Timing Configuration Window

This block sits between the host's I/O decoder and a legacy IDE port. In normal operation it is transparent: every read or write at one of the eight task-file offsets is passed straight on to the drive-side logic, and read data comes back from there unchanged.

A specific sequence of accesses opens a hidden configuration window. The sequence is two 16-bit reads of offset 1 followed by a byte write of 0x03 to offset 2. While the window is open, nothing reaches the task file. The same offsets instead reach a small register set:
- a device selector for write timing;
- a device selector for read timing, which also holds the shared address-setup code;
- one write-timing register and one read-timing register per device;
- a read-only view of the bus-clock strap pins.

Writing 0x83 to offset 2 closes the window. The per-device timing words and the setup code are driven out continuously to the strobe generator that follows this block.

Top module: `ide_cfg_window`

## Requirements
- R1: After synchronous reset the window is closed, all four timing words read 0xFF (active 15, recovery 15), the setup code is 3, and the write-timing selector is 0x00. The read-timing selector is 0x34, so read timing addresses device 0.
- R2: While the window is closed, each access is forwarded in the same cycle. `tf_rd`/`tf_wr` follow `io_rd`/`io_wr`, offset, width and write data are copied, and `io_rdata` equals `tf_rdata`. No timing word or setup code changes.
- R3: The window opens on the clock edge that ends a byte write of 0x03 to offset 2, when the two accesses just before it were 16-bit reads of offset 1. A longer run of such reads also qualifies, because only the last two count. The three accesses of the sequence are themselves forwarded. Idle cycles between accesses do not break the sequence.
- R4: Any other access between the steps cancels a partial sequence, so the full sequence has to start again. This includes a byte read of offset 1, a read of another offset, or a write of another value or offset.
- R5: While the window is open, no access is forwarded (`tf_rd` and `tf_wr` stay low). A byte write of 0x83 to offset 2 closes the window at that clock edge. Any other value written to offset 2 is ignored.
- R6: While the window is open, a read of offset 5 returns the strap code in bits [1:0] and zeros elsewhere. Codes 0, 1, 2 and 3 stand for bus clocks of 50, 40, 33 and 25 MHz.
- R7: Offset 4 holds the write-timing selector, and its bit 7 names the device (0 or 1). A byte written to offset 1 loads that device's write timing, with the active count in bits [7:4] and the recovery count in bits [3:0]. Reading offset 4 returns the selector, and reading offset 1 returns the selected device's write timing.
- R8: Offset 6 holds the read-timing selector. Bit 0 names the device, and bits [5:4] give the shared setup code on `setup_code`. A write to offset 6 takes effect only when bit 2 is set, and is otherwise ignored. Reading offset 6 returns the selector.
- R9: A byte written to offset 0 loads the read timing of the device named at offset 6, using the same nibble layout as R7. Reading offset 0 returns that device's read timing.
- R10: While the window is open, reads of offsets 2, 3 and 7 return zero, and bits [15:8] of every read are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_rd | input | 1 | Host read strobe, one cycle per access |
| io_wr | input | 1 | Host byte write strobe, one cycle per access |
| io_wide | input | 1 | Read is 16 bits wide |
| io_ofs | input | 3 | Task-file offset |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 16 | Read data returned to the host |
| clk_strap | input | 2 | Bus-clock strap pins |
| tf_rd | output | 1 | Forwarded read strobe |
| tf_wr | output | 1 | Forwarded write strobe |
| tf_wide | output | 1 | Forwarded read width |
| tf_ofs | output | 3 | Forwarded offset |
| tf_wdata | output | 8 | Forwarded write byte |
| tf_rdata | input | 16 | Read data from the task file |
| wr_timing | output | 16 | Write timing, device 1 in [15:8], device 0 in [7:0] |
| rd_timing | output | 16 | Read timing, device 1 in [15:8], device 0 in [7:0] |
| setup_code | output | 2 | Shared address-setup code |

## Verification
The pass-through path is swept over all eight offsets with byte reads, 16-bit reads and writes. A distinct data pattern is returned per offset, so a wrong offset, a wrong width or a leaked strobe each shows up separately.

The unlock logic is exercised in two ways. Broken sequences (a byte read in place of a wide one, a foreign offset in between, a wrong code, an early code write) must leave the window closed. A run of three wide reads must still open it. This separates access-based counting from cycle-based counting and from a counter that does not clear.

Inside the window, both devices are loaded with a stride of 17 through the byte range, and every strap code and every setup code is read back. This checks that the device selectors route to the right slot and that nibbles are not swapped. Keyless writes to offset 6 and foreign codes at offset 2 are then checked to have no visible effect.

// File: rtl/ide_cfg_pkg.sv
package ide_cfg_pkg;

    localparam int NDEV    = 2;
    localparam int DEV_W   = $clog2(NDEV);
    localparam int TW      = 8;
    localparam int OFS_W   = 3;
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 16;
    localparam int STRAP_W = 2;
    localparam int SETUP_W = 2;

    // offsets that carry meaning inside the window
    localparam logic [OFS_W-1:0] OFS_RDT   = 3'd0;
    localparam logic [OFS_W-1:0] OFS_WRT   = 3'd1;
    localparam logic [OFS_W-1:0] OFS_CMD   = 3'd2;
    localparam logic [OFS_W-1:0] OFS_WSEL  = 3'd4;
    localparam logic [OFS_W-1:0] OFS_STRAP = 3'd5;
    localparam logic [OFS_W-1:0] OFS_RSEL  = 3'd6;

    localparam logic [BYTE_W-1:0] OPEN_CODE  = 8'h03;
    localparam logic [BYTE_W-1:0] CLOSE_CODE = 8'h83;

    localparam logic [TW-1:0]     SLOW_TIMING = 8'hFF;
    localparam logic [BYTE_W-1:0] WSEL_INIT   = 8'h00;
    localparam logic [BYTE_W-1:0] RSEL_INIT   = 8'h34;

    localparam int WSEL_DEV_BIT = 7;
    localparam int RSEL_DEV_BIT = 0;
    localparam int RSEL_KEY_BIT = 2;
    localparam int SETUP_LSB    = 4;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ONE  = 2'd1,
        SEQ_TWO  = 2'd2
    } seq_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic              wide;
        logic [OFS_W-1:0]  ofs;
        logic [BYTE_W-1:0] wdata;
    } io_req_t;

    function automatic logic is_open_read(io_req_t r);
        return r.rd && r.wide && (r.ofs == OFS_WRT);
    endfunction

    function automatic logic is_cmd_write(io_req_t r, logic [BYTE_W-1:0] code);
        return r.wr && !r.rd && (r.ofs == OFS_CMD) && (r.wdata == code);
    endfunction

endpackage

// File: rtl/ide_unlock_seq.sv
module ide_unlock_seq
    import ide_cfg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  io_req_t req,
    output logic    cfg_q
);
    seq_e state_q, state_n;
    logic open_now, close_now;

    always_comb begin
        state_n  = state_q;
        open_now = 1'b0;
        if (!cfg_q && (req.rd || req.wr)) begin
            if (is_open_read(req)) begin
                state_n = (state_q == SEQ_IDLE) ? SEQ_ONE : SEQ_TWO;
            end else if (state_q == SEQ_TWO && is_cmd_write(req, OPEN_CODE)) begin
                open_now = 1'b1;
                state_n  = SEQ_IDLE;
            end else begin
                state_n = SEQ_IDLE;
            end
        end
    end

    assign close_now = cfg_q && is_cmd_write(req, CLOSE_CODE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cfg_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            if (open_now)
                cfg_q <= 1'b1;
            else if (close_now)
                cfg_q <= 1'b0;
        end
    end

endmodule

// File: rtl/ide_timing_bank.sv
module ide_timing_bank
    import ide_cfg_pkg::*;
#(
    parameter int             N_DEV   = NDEV,
    parameter int             WIDTH   = TW,
    parameter logic [TW-1:0]  INIT    = SLOW_TIMING,
    localparam int            SEL_W   = (N_DEV > 1) ? $clog2(N_DEV) : 1
)(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [SEL_W-1:0]         sel,
    input  logic [WIDTH-1:0]         wdata,
    output logic [N_DEV*WIDTH-1:0]   flat,
    output logic [WIDTH-1:0]         sel_word
);
    logic [WIDTH-1:0] slot_q [N_DEV];

    for (genvar g = 0; g < N_DEV; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[g] <= WIDTH'(INIT);
            else if (we && sel == SEL_W'(g))
                slot_q[g] <= wdata;
        end
        assign flat[g*WIDTH +: WIDTH] = slot_q[g];
    end

    assign sel_word = slot_q[sel];

endmodule

// File: rtl/ide_cfg_regs.sv
module ide_cfg_regs
    import ide_cfg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_q,
    input  logic                wr,
    input  logic [OFS_W-1:0]    ofs,
    input  logic [BYTE_W-1:0]   wdata,
    input  logic [STRAP_W-1:0]  strap,
    output logic [BYTE_W-1:0]   cfg_rdata,
    output logic [NDEV*TW-1:0]  wr_bank,
    output logic [NDEV*TW-1:0]  rd_bank,
    output logic [SETUP_W-1:0]  setup,
    output logic [DEV_W-1:0]    wr_dev,
    output logic [DEV_W-1:0]    rd_dev
);
    logic [BYTE_W-1:0] wsel_q, rsel_q;
    logic [TW-1:0]     wr_word, rd_word;
    logic              cwr;

    assign cwr = cfg_q && wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            wsel_q <= WSEL_INIT;
            rsel_q <= RSEL_INIT;
        end else begin
            if (cwr && ofs == OFS_WSEL)
                wsel_q <= wdata;
            if (cwr && ofs == OFS_RSEL && wdata[RSEL_KEY_BIT])
                rsel_q <= wdata;
        end
    end

    assign wr_dev = wsel_q[WSEL_DEV_BIT -: DEV_W];
    assign rd_dev = rsel_q[RSEL_DEV_BIT +: DEV_W];
    assign setup  = rsel_q[SETUP_LSB +: SETUP_W];

    ide_timing_bank #(.N_DEV(NDEV), .WIDTH(TW), .INIT(SLOW_TIMING)) u_wr_bank (
        .clk      (clk),
        .rst      (rst),
        .we       (cwr && ofs == OFS_WRT),
        .sel      (wr_dev),
        .wdata    (wdata),
        .flat     (wr_bank),
        .sel_word (wr_word)
    );

    ide_timing_bank #(.N_DEV(NDEV), .WIDTH(TW), .INIT(SLOW_TIMING)) u_rd_bank (
        .clk      (clk),
        .rst      (rst),
        .we       (cwr && ofs == OFS_RDT),
        .sel      (rd_dev),
        .wdata    (wdata),
        .flat     (rd_bank),
        .sel_word (rd_word)
    );

    always_comb begin
        case (ofs)
            OFS_RDT:   cfg_rdata = rd_word;
            OFS_WRT:   cfg_rdata = wr_word;
            OFS_WSEL:  cfg_rdata = wsel_q;
            OFS_STRAP: cfg_rdata = {{(BYTE_W-STRAP_W){1'b0}}, strap};
            OFS_RSEL:  cfg_rdata = rsel_q;
            default:   cfg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ide_cfg_window.sv
module ide_cfg_window
    import ide_cfg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 io_rd,
    input  logic                 io_wr,
    input  logic                 io_wide,
    input  logic [OFS_W-1:0]     io_ofs,
    input  logic [BYTE_W-1:0]    io_wdata,
    output logic [WORD_W-1:0]    io_rdata,
    input  logic [STRAP_W-1:0]   clk_strap,
    output logic                 tf_rd,
    output logic                 tf_wr,
    output logic                 tf_wide,
    output logic [OFS_W-1:0]     tf_ofs,
    output logic [BYTE_W-1:0]    tf_wdata,
    input  logic [WORD_W-1:0]    tf_rdata,
    output logic [NDEV*TW-1:0]   wr_timing,
    output logic [NDEV*TW-1:0]   rd_timing,
    output logic [SETUP_W-1:0]   setup_code
);
    io_req_t           req;
    logic              cfg_q;
    logic [BYTE_W-1:0] cfg_rdata;
    logic [DEV_W-1:0]  wr_dev, rd_dev;

    assign req = '{rd: io_rd, wr: io_wr, wide: io_wide, ofs: io_ofs, wdata: io_wdata};

    ide_unlock_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .cfg_q (cfg_q)
    );

    ide_cfg_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_q     (cfg_q),
        .wr        (io_wr),
        .ofs       (io_ofs),
        .wdata     (io_wdata),
        .strap     (clk_strap),
        .cfg_rdata (cfg_rdata),
        .wr_bank   (wr_timing),
        .rd_bank   (rd_timing),
        .setup     (setup_code),
        .wr_dev    (wr_dev),
        .rd_dev    (rd_dev)
    );

    assign tf_rd    = io_rd && !cfg_q;
    assign tf_wr    = io_wr && !cfg_q;
    assign tf_wide  = io_wide;
    assign tf_ofs   = io_ofs;
    assign tf_wdata = io_wdata;
    assign io_rdata = cfg_q ? {{(WORD_W-BYTE_W){1'b0}}, cfg_rdata} : tf_rdata;

endmodule

// File: rtl/ide_cfg_window_chk.sv
module ide_cfg_window_chk (
    input logic        clk,
    input logic        rst,
    input logic        io_rd,
    input logic        io_wr,
    input logic        io_wide,
    input logic [2:0]  io_ofs,
    input logic [7:0]  io_wdata,
    input logic [15:0] wr_timing,
    input logic [15:0] rd_timing,
    input logic [1:0]  setup_code,
    input logic        cfg_q,
    input logic        wr_dev,
    input logic        rd_dev
);
    // R3
    open_seq_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q && io_wr && !io_rd && io_ofs == 3'd2 && io_wdata == 8'h03
         && $past(io_rd && io_wide && io_ofs == 3'd1)
         && $past(io_rd && io_wide && io_ofs == 3'd1, 2)) |=> cfg_q);

    // R5
    close_seq_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q && io_wr && !io_rd && io_ofs == 3'd2 && io_wdata == 8'h83) |=> !cfg_q);

    // R2
    closed_no_tune_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_q |=> ($stable(wr_timing) && $stable(rd_timing) && $stable(setup_code)));

    // R8
    keyless_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q && io_wr && io_ofs == 3'd6 && !io_wdata[2]) |=> ($stable(setup_code) && $stable(rd_dev)));

    // R7
    wr_load_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q && io_wr && io_ofs == 3'd1) |=>
        (($past(wr_dev) ? wr_timing[15:8] : wr_timing[7:0]) == $past(io_wdata)));

    // R9
    rd_load_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q && io_wr && io_ofs == 3'd0) |=>
        (($past(rd_dev) ? rd_timing[15:8] : rd_timing[7:0]) == $past(io_wdata)));

endmodule

bind ide_cfg_window ide_cfg_window_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .io_rd      (io_rd),
    .io_wr      (io_wr),
    .io_wide    (io_wide),
    .io_ofs     (io_ofs),
    .io_wdata   (io_wdata),
    .wr_timing  (wr_timing),
    .rd_timing  (rd_timing),
    .setup_code (setup_code),
    .cfg_q      (cfg_q),
    .wr_dev     (wr_dev),
    .rd_dev     (rd_dev)
);

// File: tb/ide_cfg_window_test.sv
module ide_cfg_window_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_rd = 1'b0, io_wr = 1'b0, io_wide = 1'b0;
    logic [2:0]  io_ofs = '0;
    logic [7:0]  io_wdata = '0;
    logic [15:0] io_rdata;
    logic [1:0]  clk_strap = 2'd0;
    logic        tf_rd, tf_wr, tf_wide;
    logic [2:0]  tf_ofs;
    logic [7:0]  tf_wdata;
    logic [15:0] tf_rdata;
    logic [15:0] wr_timing, rd_timing;
    logic [1:0]  setup_code;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // captured at the access cycle
    logic [15:0] c_rdata;
    logic        c_tfrd, c_tfwr, c_tfwide;
    logic [2:0]  c_tfofs;
    logic [7:0]  c_tfwdata;

    // bench model of the register window
    logic [7:0] m_wt [2];
    logic [7:0] m_rt [2];
    logic [7:0] m_wsel, m_rsel;

    always #2 clk = ~clk;

    function automatic logic [15:0] tf_model(logic [2:0] o);
        return 16'h5A00 + 16'(o) * 16'h0111;
    endfunction

    assign tf_rdata = tf_model(tf_ofs);

    ide_cfg_window uut (
        .clk(clk), .rst(rst),
        .io_rd(io_rd), .io_wr(io_wr), .io_wide(io_wide), .io_ofs(io_ofs),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .clk_strap(clk_strap),
        .tf_rd(tf_rd), .tf_wr(tf_wr), .tf_wide(tf_wide), .tf_ofs(tf_ofs),
        .tf_wdata(tf_wdata), .tf_rdata(tf_rdata),
        .wr_timing(wr_timing), .rd_timing(rd_timing), .setup_code(setup_code)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic rd, input logic wr, input logic wide,
                       input logic [2:0] o, input logic [7:0] d);
        @(negedge clk);
        io_rd = rd; io_wr = wr; io_wide = wide; io_ofs = o; io_wdata = d;
        #1;
        c_rdata = io_rdata; c_tfrd = tf_rd; c_tfwr = tf_wr;
        c_tfwide = tf_wide; c_tfofs = tf_ofs; c_tfwdata = tf_wdata;
        @(posedge clk);
        #1;
        io_rd = 0; io_wr = 0; io_wide = 0;
    endtask

    task automatic rdb(input logic [2:0] o); acc(1, 0, 0, o, 8'h00); endtask
    task automatic rdw(input logic [2:0] o); acc(1, 0, 1, o, 8'h00); endtask
    task automatic wrb(input logic [2:0] o, input logic [7:0] d); acc(0, 1, 0, o, d); endtask

    task automatic open_win();
        rdw(3'd1); rdw(3'd1); wrb(3'd2, 8'h03);
    endtask

    // window open iff a strap read is not forwarded
    task automatic chk_open(input string tag, input logic exp_open);
        rdb(3'd5);
        chk(tag, {31'd0, !c_tfrd}, {31'd0, exp_open});
    endtask

    task automatic chk_timings(input string tag);
        chk(tag, {16'd0, wr_timing}, {16'd0, m_wt[1], m_wt[0]});
        chk(tag, {16'd0, rd_timing}, {16'd0, m_rt[1], m_rt[0]});
        chk(tag, {30'd0, setup_code}, {30'd0, m_rsel[5:4]});
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        m_wt[0] = 8'hFF; m_wt[1] = 8'hFF; m_rt[0] = 8'hFF; m_rt[1] = 8'hFF;
        m_wsel = 8'h00; m_rsel = 8'h34;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);

        // R1 reset state
        chk_timings("R1 reset timings");

        // R2 pass-through sweep
        for (int o = 0; o < 8; o++) begin
            rdb(3'(o));
            chk("R2 byte rd strobe", {31'd0, c_tfrd}, 32'd1);
            chk("R2 byte rd ofs", {29'd0, c_tfofs}, o);
            chk("R2 byte rd data", {16'd0, c_rdata}, {16'd0, tf_model(3'(o))});
            rdw(3'(o));
            chk("R2 wide rd", {15'd0, c_tfwide, c_rdata}, {15'd0, 1'b1, tf_model(3'(o))});
            wrb(3'(o), 8'hA0 + 8'(o));
            chk("R2 wr fwd", {23'd0, c_tfwr, c_tfwdata}, {23'd0, 1'b1, 8'hA0 + 8'(o)});
        end
        chk_timings("R2 closed writes leave timings");

        // R4 broken sequences
        rdw(3'd1); rdb(3'd1); rdw(3'd1); wrb(3'd2, 8'h03);
        chk_open("R4 byte read breaks", 1'b0);
        rdw(3'd1); rdw(3'd1); wrb(3'd2, 8'h04);
        chk_open("R4 wrong code", 1'b0);
        rdw(3'd1); rdw(3'd0); rdw(3'd1); wrb(3'd2, 8'h03);
        chk_open("R4 foreign offset", 1'b0);
        rdw(3'd1); wrb(3'd2, 8'h03);
        chk_open("R4 early code", 1'b0);
        rdw(3'd1); rdw(3'd1); wrb(3'd3, 8'h03);
        chk_open("R4 code at wrong offset", 1'b0);

        // R3 run of three wide reads still opens; sequence is forwarded
        rdw(3'd1); rdw(3'd1); rdw(3'd1);
        wrb(3'd2, 8'h03);
        chk("R3 open write forwarded", {31'd0, c_tfwr}, 32'd1);
        chk_open("R3 opened", 1'b1);

        // R6 strap codes
        for (int s = 0; s < 4; s++) begin
            clk_strap = 2'(s);
            rdw(3'd5);
            chk("R6 strap read", {16'd0, c_rdata}, s);
        end

        // R10 unmapped reads
        rdw(3'd2); chk("R10 ofs2", {16'd0, c_rdata}, 0);
        rdw(3'd3); chk("R10 ofs3", {16'd0, c_rdata}, 0);
        rdw(3'd7); chk("R10 ofs7", {16'd0, c_rdata}, 0);

        // R5 foreign value at offset 2 ignored, nothing forwarded
        wrb(3'd2, 8'h55);
        chk("R5 no fwd write", {31'd0, c_tfwr}, 32'd0);
        chk_open("R5 still open", 1'b1);

        // R7 write timing per device
        for (int dv = 0; dv < 2; dv++) begin
            m_wsel = 8'(dv << 7) | 8'h12;
            wrb(3'd4, m_wsel);
            rdb(3'd4);
            chk("R7 wsel readback", {16'd0, c_rdata}, {24'd0, m_wsel});
            for (int v = 0; v < 256; v += 17) begin
                wrb(3'd1, 8'(v));
                m_wt[dv] = 8'(v);
                chk_timings("R7 write timing");
                rdw(3'd1);
                chk("R7 readback", {16'd0, c_rdata}, v);
            end
        end

        // R8 / R9 read timing and setup code
        for (int dv = 0; dv < 2; dv++) begin
            for (int s = 0; s < 4; s++) begin
                m_rsel = 8'h04 | 8'(dv) | 8'(s << 4);
                wrb(3'd6, m_rsel);
                chk_timings("R8 setup code");
            end
            rdb(3'd6);
            chk("R8 rsel readback", {16'd0, c_rdata}, {24'd0, m_rsel});
            for (int v = 3; v < 256; v += 17) begin
                wrb(3'd0, 8'(v));
                m_rt[dv] = 8'(v);
                chk_timings("R9 read timing");
                rdb(3'd0);
                chk("R9 readback", {16'd0, c_rdata}, v);
            end
        end
        // R8 keyless write ignored: device and setup stay
        wrb(3'd6, 8'h00);
        chk_timings("R8 keyless setup");
        wrb(3'd0, 8'h5C);
        m_rt[1] = 8'h5C;
        chk_timings("R8 keyless device kept");

        // R5 close
        wrb(3'd2, 8'h83);
        chk("R5 close not forwarded", {31'd0, c_tfwr}, 32'd0);
        chk_open("R5 closed", 1'b0);
        wrb(3'd1, 8'h00);
        wrb(3'd0, 8'h00);
        chk_timings("R2 closed after window");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule